// File: doc/BRIEF.md
# Clock Output Mode and Strap Decoder

This block sits beside the synthesizer of a system clock generator. It decides how the CPU, PCI and reference output groups behave. Two mode pins select the mode. A tri-state control (`drive_en_pin`, high means normal drive) and a frequency select (`fast_sel_pin`) form a 2-bit mode code. That code chooses one of four modes:

- all groups floating;
- a test mode, where every group is derived from the incoming test clock by fixed division;
- active operation with a 66.6 MHz CPU rate;
- active operation with a 100 MHz CPU rate.

In the two active modes, the PLL path outside this block supplies the actual waveforms. The block reports the mode on `mode_o` and enables the output drivers.

The mode pins are asynchronous. They are resynchronized and then qualified, so a brief glitch never switches the outputs.

Two configuration straps share pins with the reference outputs. For that reason they are read only once, on the first cycle after reset in which `por_done` is high, and then held until the next reset. One strap enables spread-spectrum modulation. The other chooses between 48 MHz and 24 MHz on a shared output. Both straps are active low.

Top module: `clkmode_ctrl`

## Requirements
- R1: Mode code {drive_en_pin, fast_sel_pin} = 00 selects floating mode. `mode_o` reads 0, all three output enables are low, and all clock values are low.
- R2: Code 01 selects test mode, and `mode_o` reads 1. All three enables are high. `cpu_clk` is the test clock divided by 2, `pci_clk` is the test clock divided by 6, and `ref_clk` follows the test clock itself (high in every high phase).
- R3: Code 10 selects 66.6 MHz active mode (`mode_o` = 2). Code 11 selects 100 MHz active mode (`mode_o` = 3). In both, all enables are high and `cpu_clk`, `pci_clk` and `ref_clk` are held low.
- R4: On entry to test mode, both dividers restart. In the first test cycle, `cpu_clk` and `pci_clk` are both high. After that, `cpu_clk` alternates every cycle.
- R5: In test mode, `pci_clk` is high for exactly 3 test clock cycles and then low for exactly 3.
- R6: `strap_ss_n` low at capture sets `spread_en` to 1. High at capture sets it to 0.
- R7: `strap_f48_n` low at capture sets `usb_48_sel` to 1 (48 MHz). High at capture sets it to 0 (24 MHz).
- R8: The straps are captured at the first rising edge of `clk` after reset at which `por_done` is high. Until then both strap outputs read 0. Afterwards, strap pin changes and further `por_done` pulses have no effect until reset.
- R9: A new mode code held at three consecutive rising edges takes effect: `mode_o` shows it after the fifth rising edge counted from the first edge that sees it. A code held for only one or two edges never changes `mode_o`.
- R10: While `rst` is high, `mode_o`, every enable, `cpu_clk`, `pci_clk`, `ref_clk`, `spread_en` and `usb_48_sel` are all 0.
- R11: The output enables and the divided clocks respond one cycle after `mode_o` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock, also the block's clock |
| rst | input | 1 | Synchronous active-high reset |
| por_done | input | 1 | Power-on sequence finished; first high cycle captures the straps |
| drive_en_pin | input | 1 | Tri-state control, low floats the outputs (asynchronous) |
| fast_sel_pin | input | 1 | Frequency select, 1 = 100 MHz CPU (asynchronous) |
| strap_ss_n | input | 1 | Spread-spectrum strap, active low |
| strap_f48_n | input | 1 | 48/24 MHz strap, active low selects 48 MHz |
| cpu_clk | output | 1 | CPU group clock value in test mode |
| pci_clk | output | 1 | PCI group clock value in test mode |
| ref_clk | output | 1 | Reference group clock value in test mode |
| cpu_oe | output | 1 | CPU group output enable |
| pci_oe | output | 1 | PCI group output enable |
| ref_oe | output | 1 | Reference group output enable |
| mode_o | output | 2 | Committed mode code |
| spread_en | output | 1 | Latched spread-spectrum enable |
| usb_48_sel | output | 1 | Latched select, 1 = 48 MHz, 0 = 24 MHz |

## Verification
A corrupted qualifier counter or candidate register shows at the ports as a wrong edge count before `mode_o` moves, or as a glitch that changes `mode_o`. The bench therefore checks the exact commit edge, and it checks that one- and two-cycle pulses have no effect. A divider that starts in the wrong phase, or that has the wrong terminal count, misplaces a transition within the first six test cycles. Every cycle is compared against a phase counter kept in the bench. A strap latch that reopens after capture shows up at the next `por_done` pulse once the pins have been flipped, and every strap combination is swept across resets.

// File: rtl/clkmode_pkg.sv
`timescale 1ns/1ps
package clkmode_pkg;
  // Mode code as read from {drive_en_pin, fast_sel_pin}
  typedef enum logic [1:0] {
    MODE_HIZ  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_FAST = 2'b11
  } clk_mode_e;
endpackage

// File: rtl/clkmode_modesync.sv
`timescale 1ns/1ps
module clkmode_modesync
  import clkmode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pin_in,
  output clk_mode_e  mode_q
);
  localparam int CW = (STABLE_CYC > 1) ? $clog2(STABLE_CYC) : 1;

  logic [1:0] stage_q [SYNC_STAGES];
  logic [1:0] cand_q;
  logic [CW-1:0] cnt_q;

  // Resynchronizer chain; the first stage takes the raw pins
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 2'b00;
          else     stage_q[g] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 2'b00;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  // Qualifier: a candidate must repeat before it is committed
  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= 2'b00;
      cnt_q  <= '0;
      mode_q <= MODE_HIZ;
    end else if (stage_q[SYNC_STAGES-1] != cand_q) begin
      cand_q <= stage_q[SYNC_STAGES-1];
      cnt_q  <= '0;
    end else if (cnt_q != CW'(STABLE_CYC - 1)) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      mode_q <= clk_mode_e'(cand_q);
    end
  end
endmodule

// File: rtl/clkmode_div.sv
`timescale 1ns/1ps
module clkmode_div #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic q
);
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  // Even divider: high for the first half of each period, restarts when idle
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      q     <= 1'b0;
    end else begin
      q     <= (cnt_q < CW'(HALF));
      cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/clkmode_strap.sv
`timescale 1ns/1ps
module clkmode_strap (
  input  logic clk,
  input  logic rst,
  input  logic por_done,
  input  logic strap_ss_n,
  input  logic strap_f48_n,
  output logic spread_en,
  output logic usb_48_sel
);
  logic taken_q;

  // One-shot capture on the first power-on-done cycle after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q    <= 1'b0;
      spread_en  <= 1'b0;
      usb_48_sel <= 1'b0;
    end else if (por_done && !taken_q) begin
      taken_q    <= 1'b1;
      spread_en  <= ~strap_ss_n;
      usb_48_sel <= ~strap_f48_n;
    end
  end
endmodule

// File: rtl/clkmode_ctrl.sv
`timescale 1ns/1ps
module clkmode_ctrl
  import clkmode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2,
  parameter int CPU_DIV     = 2,
  parameter int PCI_DIV     = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       por_done,
  input  logic       drive_en_pin,
  input  logic       fast_sel_pin,
  input  logic       strap_ss_n,
  input  logic       strap_f48_n,
  output logic       cpu_clk,
  output logic       pci_clk,
  output logic       ref_clk,
  output logic       cpu_oe,
  output logic       pci_oe,
  output logic       ref_oe,
  output logic [1:0] mode_o,
  output logic       spread_en,
  output logic       usb_48_sel
);
  clk_mode_e mode_q;
  logic      run_test;
  logic      oe_q;
  logic      ref_en_q;

  clkmode_modesync #(.SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in ({drive_en_pin, fast_sel_pin}),
    .mode_q (mode_q)
  );

  assign run_test = (mode_q == MODE_TEST);

  clkmode_div #(.DIV(CPU_DIV)) u_cpu_div (
    .clk (clk), .rst (rst), .run (run_test), .q (cpu_clk)
  );

  clkmode_div #(.DIV(PCI_DIV)) u_pci_div (
    .clk (clk), .rst (rst), .run (run_test), .q (pci_clk)
  );

  // Reference gate enable changes only while the clock is low
  always_ff @(negedge clk) begin
    if (rst) ref_en_q <= 1'b0;
    else     ref_en_q <= run_test;
  end
  assign ref_clk = clk & ref_en_q;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= (mode_q != MODE_HIZ);
  end

  assign cpu_oe = oe_q;
  assign pci_oe = oe_q;
  assign ref_oe = oe_q;
  assign mode_o = mode_q;

  clkmode_strap u_strap (
    .clk         (clk),
    .rst         (rst),
    .por_done    (por_done),
    .strap_ss_n  (strap_ss_n),
    .strap_f48_n (strap_f48_n),
    .spread_en   (spread_en),
    .usb_48_sel  (usb_48_sel)
  );
endmodule

// File: rtl/clkmode_ctrl_chk.sv
`timescale 1ns/1ps
module clkmode_ctrl_chk
  import clkmode_pkg::*;
#(
  parameter int PCI_DIV = 6
) (
  input logic       clk,
  input logic       rst,
  input logic       por_done,
  input logic       cpu_clk,
  input logic       pci_clk,
  input logic       cpu_oe,
  input logic       pci_oe,
  input logic       ref_oe,
  input logic [1:0] mode_o,
  input logic       spread_en,
  input logic       usb_48_sel
);
  localparam int HALF = PCI_DIV / 2;

  logic [7:0] hi_cnt;
  logic       seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      seen_q <= 1'b0;
    end else begin
      hi_cnt <= pci_clk ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
      seen_q <= seen_q | por_done;
    end
  end

  // R1
  hiz_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_HIZ) |=> (!cpu_oe && !pci_oe && !ref_oe));

  // R11
  drive_oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != MODE_HIZ) |=> (cpu_oe && pci_oe && ref_oe));

  // R3
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o != MODE_TEST) |=> (!cpu_clk && !pci_clk));

  // R4
  cpu_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_TEST && $past(mode_o) == MODE_TEST) |-> (cpu_clk != $past(cpu_clk)));

  // R5
  pci_high_max_chk: assert property (@(posedge clk) disable iff (rst)
    pci_clk |-> (hi_cnt < 8'(HALF)));

  // R5
  pci_high_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(pci_clk) && mode_o == MODE_TEST) |-> (hi_cnt == 8'(HALF)));

  // R8
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(seen_q)) |-> ($stable(spread_en) && $stable(usb_48_sel)));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk #(.PCI_DIV(PCI_DIV)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .por_done   (por_done),
  .cpu_clk    (cpu_clk),
  .pci_clk    (pci_clk),
  .cpu_oe     (cpu_oe),
  .pci_oe     (pci_oe),
  .ref_oe     (ref_oe),
  .mode_o     (mode_o),
  .spread_en  (spread_en),
  .usb_48_sel (usb_48_sel)
);

// File: tb/test_clkmode_ctrl.sv
`timescale 1ns/1ps
module test_clkmode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_done = 1'b0;
  logic       drive_en_pin = 1'b0;
  logic       fast_sel_pin = 1'b0;
  logic       strap_ss_n = 1'b1;
  logic       strap_f48_n = 1'b1;
  logic       cpu_clk, pci_clk, ref_clk, cpu_oe, pci_oe, ref_oe;
  logic [1:0] mode_o;
  logic       spread_en, usb_48_sel;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  clkmode_ctrl i_clkmode_ctrl (
    .clk (clk), .rst (rst), .por_done (por_done),
    .drive_en_pin (drive_en_pin), .fast_sel_pin (fast_sel_pin),
    .strap_ss_n (strap_ss_n), .strap_f48_n (strap_f48_n),
    .cpu_clk (cpu_clk), .pci_clk (pci_clk), .ref_clk (ref_clk),
    .cpu_oe (cpu_oe), .pci_oe (pci_oe), .ref_oe (ref_oe),
    .mode_o (mode_o), .spread_en (spread_en), .usb_48_sel (usb_48_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_code(input logic [1:0] c);
    drive_en_pin = c[1];
    fast_sel_pin = c[0];
  endtask

  // Called at a negedge; moves from prev to code and checks the mode's outputs
  task automatic go_mode(input logic [1:0] code, input logic [1:0] prev);
    int oe_exp;
    drive_code(code);
    repeat (4) @(negedge clk);
    chk(mode_o == prev, "R9 mode held before commit edge", mode_o, prev);
    @(negedge clk);
    chk(mode_o == code, "R9 mode committed on fifth edge", mode_o, code);
    chk(cpu_oe == (prev != 2'b00), "R11 oe lags mode", cpu_oe, prev != 2'b00);
    @(negedge clk);
    oe_exp = (code != 2'b00);
    chk(cpu_oe == oe_exp && pci_oe == oe_exp && ref_oe == oe_exp,
        (code == 2'b00) ? "R1 enables low" : "R2 R3 R11 enables high",
        {cpu_oe, pci_oe, ref_oe}, oe_exp ? 7 : 0);
    for (int k = 0; k < 24; k++) begin
      if (code == 2'b01) begin
        chk(cpu_clk == (k % 2 == 0), "R2 R4 cpu div2", cpu_clk, k % 2 == 0);
        chk(pci_clk == (k % 6 < 3), "R2 R4 R5 pci div6", pci_clk, k % 6 < 3);
      end else begin
        chk(cpu_clk == 1'b0 && pci_clk == 1'b0,
            (code == 2'b00) ? "R1 clocks low" : "R3 clocks low", {cpu_clk, pci_clk}, 0);
      end
      chk(ref_clk == 1'b0, "R2 ref low in low phase", ref_clk, 0);
      @(posedge clk); #1;
      chk(ref_clk == (code == 2'b01), "R2 R3 ref follows clock", ref_clk, code == 2'b01);
      @(negedge clk);
    end
  endtask

  initial begin
    #(100000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Strap sweep: every combination, captured then disturbed
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rst = 1'b1;
      por_done = 1'b0;
      drive_code(2'b00);
      strap_ss_n = s[0];
      strap_f48_n = s[1];
      repeat (3) @(negedge clk);
      chk(mode_o == 2'b00 && !cpu_oe && !pci_oe && !ref_oe && !cpu_clk && !pci_clk
          && !spread_en && !usb_48_sel, "R10 reset state",
          {mode_o, cpu_oe, pci_oe, ref_oe, spread_en, usb_48_sel}, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);
      chk(!spread_en && !usb_48_sel, "R8 no capture before por_done",
          {spread_en, usb_48_sel}, 0);
      por_done = 1'b1;
      @(negedge clk);
      chk(spread_en == !s[0], "R6 spread strap", spread_en, !s[0]);
      chk(usb_48_sel == !s[1], "R7 48/24 strap", usb_48_sel, !s[1]);
      strap_ss_n = !s[0];
      strap_f48_n = !s[1];
      repeat (2) @(negedge clk);
      por_done = 1'b0;
      repeat (2) @(negedge clk);
      por_done = 1'b1;
      repeat (3) @(negedge clk);
      chk(spread_en == !s[0] && usb_48_sel == !s[1], "R8 straps held",
          {spread_en, usb_48_sel}, {!s[1] ? 1'b1 : 1'b0, !s[0] ? 1'b1 : 1'b0} == 2'b00 ? 0 :
          int'({1'b0, 1'b0}) + (!s[0] ? 2 : 0) + (!s[1] ? 1 : 0));
    end

    // Mode sweep with transitions into test from several modes
    go_mode(2'b01, 2'b00);
    go_mode(2'b10, 2'b01);
    go_mode(2'b01, 2'b10);
    go_mode(2'b11, 2'b01);
    go_mode(2'b01, 2'b11);
    go_mode(2'b00, 2'b01);

    // Glitch filtering: one and two edges ignored
    for (int len = 1; len <= 2; len++) begin
      drive_code(2'b01);
      repeat (len) @(negedge clk);
      drive_code(2'b00);
      for (int w = 0; w < 8; w++) begin
        @(negedge clk);
        chk(mode_o == 2'b00 && !cpu_oe, "R9 short pulse ignored", mode_o, 0);
      end
    end
    // Three edges are enough
    drive_code(2'b11);
    repeat (3) @(negedge clk);
    drive_code(2'b00);
    repeat (2) @(negedge clk);
    chk(mode_o == 2'b11, "R9 three-edge pulse commits", mode_o, 3);
    repeat (6) @(negedge clk);
    chk(mode_o == 2'b00, "R9 returns to floating", mode_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule